// File: doc/BRIEF.md
# Coded Audio Clock Divider

This block turns one module clock into the clocks an audio serializer needs: a master clock for the converter, a bit clock, and a frame (left/right) clock. Software writes one 8-bit divider word. The word holds a 4-bit master-clock code, a 3-bit bit-clock code and an output enable for the master-clock pin. Each code selects a fixed ratio from a small table. The ratios are not all powers of two.

The dividers are chained. The master-clock divider counts module-clock cycles. The bit-clock divider counts master-clock periods. The frame clock changes level after a fixed number of bit-clock periods, one slot. Every divided output has a 50% duty cycle, low in the first half of its period. Software picks the codes from the sample rate and the oversampling ratio: master = module / (fs × oversample), and the bit-clock ratio is oversample / 32 for 16-bit stereo.

A new divider word waits in a holding register. It is taken into use only at the end of a bit-clock period, so the outputs never show a shortened pulse. A strobe marks the last module cycle of each bit-clock period, and the serializer uses it as its shift enable.

Top module: `ac_clkgen`

## Requirements
- R1: The master-clock code in bits 3:0 selects the ratios 1, 2, 4, 6, 8, 12, 16 and 24 for codes 0 to 7. Codes 8 to 15 divide by 24.
- R2: For a master ratio M greater than 1, the enabled master-clock pin has period M module cycles. It is low for the first M/2 cycles of each period and high for the rest.
- R3: With a master ratio of 1, the enabled master-clock pin follows the module clock.
- R4: Bit 7 of the divider word enables the master-clock pin. While bit 7 is 0, the pin stays low.
- R5: The bit-clock code in bits 6:4 selects the ratios 2, 4, 6, 8, 12 and 16 master periods for codes 0 to 5. Codes 6 and 7 divide by 16. The bit clock has period M×B module cycles, low for the first half and high for the second.
- R6: The bit strobe is high in exactly one module cycle per bit-clock period, the last one.
- R7: The frame clock changes level once every SLOT_BITS bit-clock periods, in the cycle after a bit strobe.
- R8: A written word takes effect after the first bit strobe that follows the write cycle. All divided outputs then start a fresh period in the low phase, and no period before that point is cut short.
- R9: Reset clears the divider word to 0 (ratio 1, bit ratio 2, pin disabled) and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 8 | Divider word: [3:0] master code, [6:4] bit code, [7] pin enable |
| mclk_pin | output | 1 | Master-clock output pin |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| bit_stb | output | 1 | High in the last module cycle of each bit-clock period |

## Verification
Every divided output comes from a register, so each output shows its new value in the cycle after the clock edge that advances the counters. The bench samples at the falling edge. It keeps a cycle index from the last point where a word took effect and predicts each output from that index. A written word becomes pending at the edge that captures it. It takes effect at the edge that ends the first later cycle with a bit strobe, and index 0 is the cycle after that edge. The bench goes on checking the old pattern until then, which detects a word applied too early. The gated master clock at ratio 1 is also sampled 2 ns after the rising edge, while the module clock is high.

// File: rtl/ac_clk_pkg.sv
package ac_clk_pkg;

    localparam int MCODE_W = 4;
    localparam int BCODE_W = 3;
    localparam int CNT_W   = 5;
    localparam int CFG_W   = MCODE_W + BCODE_W + 1;

    typedef struct packed {
        logic               oe;
        logic [BCODE_W-1:0] bcode;
        logic [MCODE_W-1:0] mcode;
    } div_cfg_t;

    // master ratio lookup: reserved codes fall back to the largest ratio
    function automatic logic [CNT_W-1:0] mclk_ratio(input logic [MCODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            4'd0:    r = CNT_W'(1);
            4'd1:    r = CNT_W'(2);
            4'd2:    r = CNT_W'(4);
            4'd3:    r = CNT_W'(6);
            4'd4:    r = CNT_W'(8);
            4'd5:    r = CNT_W'(12);
            4'd6:    r = CNT_W'(16);
            default: r = CNT_W'(24);
        endcase
        return r;
    endfunction

    // bit ratio lookup (in master periods): codes 6 and 7 act as 16
    function automatic logic [CNT_W-1:0] bclk_ratio(input logic [BCODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd0:    r = CNT_W'(2);
            3'd1:    r = CNT_W'(4);
            3'd2:    r = CNT_W'(6);
            3'd3:    r = CNT_W'(8);
            3'd4:    r = CNT_W'(12);
            default: r = CNT_W'(16);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ac_mclk_div.sv
module ac_mclk_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio,
    output logic             mtick,
    output logic             sq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sq;
    } mst_t;

    mst_t st_d, st_q;
    logic last;

    always_comb begin
        st_d     = st_q;
        last     = (st_q.cnt == ratio - CNT_W'(1));
        st_d.cnt = last ? '0 : st_q.cnt + CNT_W'(1);
        // low half first, high half second; ratio 1 uses the gated clock instead
        st_d.sq  = (ratio != CNT_W'(1)) && (st_d.cnt >= (ratio >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mtick = last;
    assign sq    = st_q.sq;

    AST_MCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ratio); // R1
    AST_MCLK_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sq) |-> (st_q.cnt == (ratio >> 1))); // R2
    AST_MCLK_FALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sq) |-> (st_q.cnt == '0)); // R2

endmodule

// File: rtl/ac_bclk_div.sv
module ac_bclk_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] ratio,
    output logic             btick,
    output logic             bclk
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk;
    } bst_t;

    bst_t st_d, st_q;
    logic last;

    always_comb begin
        st_d  = st_q;
        last  = (st_q.cnt == ratio - CNT_W'(1));
        btick = step && last;
        if (step) begin
            st_d.cnt = last ? '0 : st_q.cnt + CNT_W'(1);
        end
        st_d.clk = (st_d.cnt >= (ratio >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk = st_q.clk;

    AST_BCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ratio); // R5
    AST_BCLK_ON_MTICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.clk) |-> $past(step)); // R5

endmodule

// File: rtl/ac_frame_ctr.sv
module ac_frame_ctr #(
    parameter int SLOT_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btick,
    output logic lrclk
);

    localparam int SW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          lr;
    } fst_t;

    fst_t st_d, st_q;
    logic slot_end;

    always_comb begin
        st_d     = st_q;
        slot_end = (st_q.slot == SW'(SLOT_BITS - 1));
        if (btick) begin
            st_d.slot = slot_end ? '0 : st_q.slot + SW'(1);
            if (slot_end) st_d.lr = ~st_q.lr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lrclk = st_q.lr;

    AST_LR_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lr) |-> $past(btick)); // R7

endmodule

// File: rtl/ac_clkgen.sv
module ac_clkgen #(
    parameter int SLOT_BITS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic [ac_clk_pkg::CFG_W-1:0] cfg_wdata,
    output logic                        mclk_pin,
    output logic                        bclk,
    output logic                        lrclk,
    output logic                        bit_stb
);

    import ac_clk_pkg::*;

    typedef struct packed {
        div_cfg_t cfg;
        div_cfg_t pend;
        logic     pend_v;
    } top_t;

    top_t st_d, st_q;
    logic apply;
    logic mtick, btick, msq;
    logic [CNT_W-1:0] m_ratio, b_ratio;

    assign m_ratio = mclk_ratio(st_q.cfg.mcode);
    assign b_ratio = bclk_ratio(st_q.cfg.bcode);

    always_comb begin
        st_d  = st_q;
        apply = st_q.pend_v && btick;
        if (apply) begin
            st_d.cfg    = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        // a write landing on the apply cycle stays pending for the next boundary
        if (cfg_wr) begin
            st_d.pend   = div_cfg_t'(cfg_wdata);
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ac_mclk_div #(.CNT_W(CNT_W)) u_mdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (m_ratio),
        .mtick (mtick),
        .sq    (msq)
    );

    ac_bclk_div #(.CNT_W(CNT_W)) u_bdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (mtick),
        .ratio (b_ratio),
        .btick (btick),
        .bclk  (bclk)
    );

    ac_frame_ctr #(.SLOT_BITS(SLOT_BITS)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .btick (btick),
        .lrclk (lrclk)
    );

    assign mclk_pin = st_q.cfg.oe & ((m_ratio == CNT_W'(1)) ? clk : msq);
    assign bit_stb  = btick;

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cfg) |-> $past(btick)); // R8
    AST_STB_ON_MTICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> mtick); // R6

endmodule

// File: tb/sim_ac_clkgen.sv
`timescale 1ns/1ps
module sim_ac_clkgen;

    localparam int SLOT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       mclk_pin, bclk, lrclk, bit_stb;

    ac_clkgen #(.SLOT_BITS(SLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .mclk_pin(mclk_pin), .bclk(bclk), .lrclk(lrclk), .bit_stb(bit_stb)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // active expectation
    int cur_m = 1, cur_b = 2, cur_en = 0, k = 0;
    int nxt_m, nxt_b, nxt_en;
    bit pend = 0;
    string cur_tag = "R9";
    // mismatch bookkeeping for the current window
    int mm_m, mm_b, mm_s;
    int fm_k, fb_k, fs_k, fm_a, fm_e, fb_a, fb_e, fs_a, fs_e;
    // frame edge tracking
    int cyc = 0, lr_edges = 0, lr_edge_cyc = 0, lr_gap = 0;
    logic lr_prev = 1'b0;

    function automatic int ref_mratio(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; 6: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic int ref_bratio(input int c);
        case (c)
            0: return 2; 1: return 4; 2: return 6; 3: return 8; 4: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_window();
        mm_m = 0; mm_b = 0; mm_s = 0;
    endtask

    task automatic report_window();
        checks += 3;
        if (mm_m != 0) begin
            errors++;
            $display("FAIL %s mclk_pin (M=%0d en=%0d) idx %0d: actual=%0d expected=%0d",
                     cur_tag, cur_m, cur_en, fm_k, fm_a, fm_e);
        end
        if (mm_b != 0) begin
            errors++;
            $display("FAIL R5 bclk (M=%0d B=%0d) idx %0d: actual=%0d expected=%0d",
                     cur_m, cur_b, fb_k, fb_a, fb_e);
        end
        if (mm_s != 0) begin
            errors++;
            $display("FAIL R6/R8 bit_stb (M=%0d B=%0d) idx %0d: actual=%0d expected=%0d",
                     cur_m, cur_b, fs_k, fs_a, fs_e);
        end
        clear_window();
    endtask

    // sample at the falling edge, pass one rising edge, return at the next falling edge
    task automatic step();
        int mb, em, eb, es;
        bit apply_now;
        mb = cur_m * cur_b;
        em = (cur_m != 1 && cur_en != 0 && (k % cur_m) >= cur_m / 2) ? 1 : 0;
        eb = ((k % mb) >= mb / 2) ? 1 : 0;
        es = ((k % mb) == mb - 1) ? 1 : 0;
        if (int'(mclk_pin) != em && mm_m++ == 0) begin fm_k = k; fm_a = int'(mclk_pin); fm_e = em; end
        if (int'(bclk) != eb && mm_b++ == 0)     begin fb_k = k; fb_a = int'(bclk);     fb_e = eb; end
        if (int'(bit_stb) != es && mm_s++ == 0)  begin fs_k = k; fs_a = int'(bit_stb);  fs_e = es; end
        if (lrclk !== lr_prev) begin
            lr_gap = cyc - lr_edge_cyc;
            lr_edge_cyc = cyc;
            lr_edges++;
            lr_prev = lrclk;
        end
        apply_now = pend && (es == 1);
        @(posedge clk);
        #2;
        // R3: gated pass-through while the module clock is high
        if (!apply_now && cur_m == 1 && int'(mclk_pin) != cur_en && mm_m++ == 0) begin
            fm_k = k; fm_a = int'(mclk_pin); fm_e = cur_en;
        end
        @(negedge clk);
        cyc++;
        if (apply_now) begin
            report_window();
            cur_m = nxt_m; cur_b = nxt_b; cur_en = nxt_en;
            cur_tag = (cur_en == 0) ? "R4" : ((cur_m == 1) ? "R3" : "R2");
            pend = 0;
            k = 0;
        end else begin
            k++;
        end
    endtask

    // R8: write, keep checking the old pattern until the boundary, then the new one
    task automatic run_cfg(input int mcode, input int bcode, input int en);
        cfg_wdata = {en[0], bcode[2:0], mcode[3:0]};
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        nxt_m = ref_mratio(mcode);
        nxt_b = ref_bratio(bcode);
        nxt_en = en;
        pend = 1;
        while (pend) step();
        for (int i = 0; i < 2 * cur_m * cur_b + 3; i++) step();
    endtask

    // R7: spacing of two consecutive frame-clock edges under the active word
    task automatic measure_lr();
        int e0;
        e0 = lr_edges;
        while (lr_edges < e0 + 2) step();
        check("R7", "frame edge spacing", lr_gap, SLOT * cur_m * cur_b);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_A0D1));
        clear_window();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "mclk_pin in reset", int'(mclk_pin), 0);
        check("R9", "bclk in reset", int'(bclk), 0);
        check("R9", "lrclk in reset", int'(lrclk), 0);
        check("R9", "bit_stb in reset", int'(bit_stb), 0);
        rst_n = 1'b1;
        // reset word (ratio 1, bit ratio 2, disabled) checked for a while
        for (int i = 0; i < 40; i++) step();
        measure_lr();

        run_cfg(0, 0, 1);   // R3 pass-through
        run_cfg(3, 2, 0);   // R4 divide by 6, pin disabled
        run_cfg(1, 1, 1);   // R1 R2 R5
        measure_lr();       // R7 with M=2, B=4
        run_cfg(9, 7, 1);   // R1 R5 reserved codes -> 24 and 16
        run_cfg(7, 5, 1);   // largest legal ratios
        run_cfg(5, 6, 1);   // R5 reserved code 6
        run_cfg(2, 0, 1);   // R8 switch from a long period to a short one

        for (int n = 0; n < 8; n++) begin
            run_cfg(int'($urandom % 16), int'($urandom % 8), int'($urandom % 2));
        end
        report_window();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule